// File: doc/BRIEF.md
# E3 Maintenance Byte Monitor

This block watches the maintenance byte that an E3 receive framer extracts once per frame. The byte arrives on an 8-bit bus with a one-cycle strobe. The block watches three fields in it. The far-end receive failure bit and the timing marker bit each pass through their own persistence filter, which changes state only after a run of agreeing frames. The run length is 3 or 5 frames, chosen by one select input per filter. The 3-bit payload type is captured on every strobe and compared with a programmed expected value. When the two start to differ, the block raises a level flag and a one-cycle interrupt pulse.

A mode input selects the later framing revision. In that mode the payload comparison is forced off and the timing marker filter is frozen. The failure filter keeps running. The block sits beside the frame aligner. It has no host interface: configuration and status are plain signals.

Byte layout, MSB first: bit 7 is the far-end failure bit, bit 6 is the far-end block error bit (not monitored), bits 5 to 3 are the payload type, bits 2 to 1 are the multiframe indicator (not monitored), and bit 0 is the timing marker.

Each filter is a two-state machine. The states are FLT_CLEAR (filtered value 0) and FLT_SET (filtered value 1). The transitions are RISE (FLT_CLEAR to FLT_SET) and FALL (FLT_SET to FLT_CLEAR). A filter takes a transition when the number of consecutive sampled frames whose bit differs from the current state reaches N. A sampled frame whose bit agrees with the state clears the count. The payload checker is a two-state machine with states PT_MATCH and PT_MISMATCH. Its transitions are DIVERGE (PT_MATCH to PT_MISMATCH, which fires the interrupt) and CONVERGE (PT_MISMATCH to PT_MATCH).

Top module: `e3_ma_monitor`

## Requirements
- R1: After a synchronous active-high reset, `ferf_state`, `tmark_state`, `pt_received`, `pt_mismatch` and `pt_mismatch_irq` are all 0.
- R2: On each cycle with `ma_valid` high, `pt_received` takes bits 5..3 of `ma_byte`. It is visible after that clock edge and is held until the next strobe.
- R3: With `ferf_len5` at 0, `ferf_state` becomes 1 after the edge of the third consecutive strobed frame with bit 7 at 1. It returns to 0 after the third consecutive strobed frame with bit 7 at 0.
- R4: With `ferf_len5` at 1, both the set and the clear of `ferf_state` need 5 consecutive strobed frames instead of 3.
- R5: A strobed frame whose monitored bit equals the current filtered state resets the run, so a broken run never changes the filtered state.
- R6: `tmark_state` takes bit 0 only after that bit holds the new value for N consecutive strobed frames, where N is 3 when `tmark_len5` is 0 and 5 when it is 1. It keeps its value otherwise.
- R7: `pt_mismatch` is high, one clock after the captured payload type or the configuration changes, exactly when `pt_received` differs from `pt_expected`. `pt_mismatch_irq` pulses for one cycle on each rise of that condition.
- R8: With `late_rev_mode` at 1:
    - `pt_mismatch` and `pt_mismatch_irq` stay low.
    - `tmark_state` and its run count are frozen.
    - The failure filter keeps working.
- R9: Cycles with `ma_valid` low change no filter, counter or captured value, whatever is on `ma_byte`.
- R10: A change of a length select while a run is in progress applies from the next strobed frame. A run already at or past the new N changes state on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ma_valid | input | 1 | One-cycle strobe per received frame |
| ma_byte | input | 8 | Maintenance byte of the frame |
| ferf_len5 | input | 1 | Failure filter length select: 0 for 3 frames, 1 for 5 frames |
| tmark_len5 | input | 1 | Timing marker filter length select: 0 for 3 frames, 1 for 5 frames |
| late_rev_mode | input | 1 | Later framing revision: disables the payload check and the timing marker filter |
| pt_expected | input | 3 | Expected payload type |
| ferf_state | output | 1 | Filtered far-end receive failure |
| tmark_state | output | 1 | Validated timing marker |
| pt_received | output | 3 | Payload type of the latest frame |
| pt_mismatch | output | 1 | Payload type mismatch level |
| pt_mismatch_irq | output | 1 | One-cycle pulse on a new mismatch |

## Verification
The filter outputs and `pt_received` are due on the clock edge that samples the strobe. The bench therefore checks them on the falling edge right after that edge. The mismatch level and the interrupt come one register later. They are checked on the falling edge after the next rising edge, and the pulse is compared against the rise of the bench's own mismatch model. Configuration changes to the expected type or to the mode are applied alone, away from any frame. Their mismatch effect is sampled one edge later.

// File: rtl/e3ma_pkg.sv
package e3ma_pkg;
    typedef enum logic {
        FLT_CLEAR = 1'b0,
        FLT_SET   = 1'b1
    } flt_state_t;

    typedef enum logic {
        PT_MATCH    = 1'b0,
        PT_MISMATCH = 1'b1
    } pt_state_t;

    localparam int MA_W     = 8;
    localparam int PT_W     = 3;
    localparam int FERF_POS = 7;
    localparam int PT_HI    = 5;
    localparam int PT_LO    = 3;
    localparam int TM_POS   = 0;
endpackage

// File: rtl/e3ma_persist_filter.sv
module e3ma_persist_filter
    import e3ma_pkg::*;
#(
    parameter int SHORT_LEN = 3,
    parameter int LONG_LEN  = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  logic bit_in,
    input  logic long_sel,
    output logic filt_out
);
    localparam int CNT_W = $clog2(LONG_LEN + 1);

    flt_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_inc;
    logic             disagree;
    logic             run_done;

    assign limit    = long_sel ? CNT_W'(LONG_LEN) : CNT_W'(SHORT_LEN);
    assign cnt_inc  = cnt_q + 1'b1;
    assign disagree = sample && (bit_in != logic'(state_q));
    assign run_done = disagree && (cnt_inc >= limit);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FLT_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: RISE / FALL on a completed run
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_CLEAR: if (run_done) state_d = FLT_SET;
            FLT_SET:   if (run_done) state_d = FLT_CLEAR;
            default:   state_d = FLT_CLEAR;
        endcase
    end

    // run counter and output
    always_comb begin
        cnt_d = cnt_q;
        if (sample) begin
            if (!disagree || run_done) cnt_d = '0;
            else                       cnt_d = cnt_inc;
        end
        filt_out = (state_q == FLT_SET);
    end
endmodule

// File: rtl/e3ma_pt_check.sv
module e3ma_pt_check
    import e3ma_pkg::*;
#(
    parameter int W = PT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         frame_valid,
    input  logic [W-1:0] pt_field,
    input  logic [W-1:0] pt_expected,
    input  logic         legacy_off,
    output logic [W-1:0] pt_rx,
    output logic         mismatch,
    output logic         irq
);
    pt_state_t    state_q, state_d;
    logic [W-1:0] pt_q;
    logic         irq_q;
    logic         differ;

    assign differ = !legacy_off && (pt_q != pt_expected);

    // state register, capture and pulse register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PT_MATCH;
            pt_q    <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            irq_q   <= (state_q == PT_MATCH) && (state_d == PT_MISMATCH);
            if (frame_valid) pt_q <= pt_field;
        end
    end

    // next state: DIVERGE / CONVERGE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PT_MATCH:    if (differ)  state_d = PT_MISMATCH;
            PT_MISMATCH: if (!differ) state_d = PT_MATCH;
            default:     state_d = PT_MATCH;
        endcase
    end

    // outputs
    always_comb begin
        pt_rx    = pt_q;
        mismatch = (state_q == PT_MISMATCH);
        irq      = irq_q;
    end
endmodule

// File: rtl/e3_ma_monitor.sv
module e3_ma_monitor
    import e3ma_pkg::*;
#(
    parameter int SHORT_LEN = 3,
    parameter int LONG_LEN  = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ma_valid,
    input  logic [MA_W-1:0] ma_byte,
    input  logic            ferf_len5,
    input  logic            tmark_len5,
    input  logic            late_rev_mode,
    input  logic [PT_W-1:0] pt_expected,
    output logic            ferf_state,
    output logic            tmark_state,
    output logic [PT_W-1:0] pt_received,
    output logic            pt_mismatch,
    output logic            pt_mismatch_irq
);
    logic tm_sample;

    assign tm_sample = ma_valid && !late_rev_mode;

    e3ma_persist_filter #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) ferf_flt_i (
        .clk      (clk),
        .rst      (rst),
        .sample   (ma_valid),
        .bit_in   (ma_byte[FERF_POS]),
        .long_sel (ferf_len5),
        .filt_out (ferf_state)
    );

    e3ma_persist_filter #(.SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) tm_flt_i (
        .clk      (clk),
        .rst      (rst),
        .sample   (tm_sample),
        .bit_in   (ma_byte[TM_POS]),
        .long_sel (tmark_len5),
        .filt_out (tmark_state)
    );

    e3ma_pt_check #(.W(PT_W)) pt_i (
        .clk         (clk),
        .rst         (rst),
        .frame_valid (ma_valid),
        .pt_field    (ma_byte[PT_HI:PT_LO]),
        .pt_expected (pt_expected),
        .legacy_off  (late_rev_mode),
        .pt_rx       (pt_received),
        .mismatch    (pt_mismatch),
        .irq         (pt_mismatch_irq)
    );
endmodule

// File: rtl/e3ma_checker.sv
module e3ma_checker (
    input logic       clk,
    input logic       rst,
    input logic       ma_valid,
    input logic       late_rev_mode,
    input logic       ferf_state,
    input logic       tmark_state,
    input logic [2:0] pt_received,
    input logic       pt_mismatch,
    input logic       pt_mismatch_irq
);
    // R7: pulse only while mismatch is reported
    a_r7_irq_with_level: assert property (@(posedge clk) disable iff (rst)
        pt_mismatch_irq |-> pt_mismatch);

    // R7: the interrupt lasts one cycle
    a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
        pt_mismatch_irq |=> !pt_mismatch_irq);

    // R8: mismatch held low in the later-revision mode
    a_r8_legacy_no_mismatch: assert property (@(posedge clk) disable iff (rst)
        late_rev_mode |=> !pt_mismatch);

    // R8: the timing marker is frozen in the later-revision mode
    a_r8_legacy_tmark_frozen: assert property (@(posedge clk) disable iff (rst)
        late_rev_mode |=> $stable(tmark_state));

    // R9: without a strobe nothing captured moves
    a_r9_ferf_idle: assert property (@(posedge clk) disable iff (rst)
        !ma_valid |=> $stable(ferf_state));

    a_r9_tmark_idle: assert property (@(posedge clk) disable iff (rst)
        !ma_valid |=> $stable(tmark_state));

    a_r2_pt_held: assert property (@(posedge clk) disable iff (rst)
        !ma_valid |=> $stable(pt_received));
endmodule

bind e3_ma_monitor e3ma_checker chk_i (
    .clk             (clk),
    .rst             (rst),
    .ma_valid        (ma_valid),
    .late_rev_mode   (late_rev_mode),
    .ferf_state      (ferf_state),
    .tmark_state     (tmark_state),
    .pt_received     (pt_received),
    .pt_mismatch     (pt_mismatch),
    .pt_mismatch_irq (pt_mismatch_irq)
);

// File: tb/e3_ma_monitor_tb_top.sv
`timescale 1ns/1ps
module e3_ma_monitor_tb_top;
    logic       clk = 1'b0;
    logic       rst;
    logic       ma_valid;
    logic [7:0] ma_byte;
    logic       ferf_len5, tmark_len5, late_rev_mode;
    logic [2:0] pt_expected;
    logic       ferf_state, tmark_state;
    logic [2:0] pt_received;
    logic       pt_mismatch, pt_mismatch_irq;

    int n_checks = 0;
    int n_errors = 0;

    // bench model
    logic       m_ferf, m_tm, m_mis;
    int         m_fcnt, m_tcnt;
    logic [2:0] m_pt;

    always #4 clk = ~clk;

    e3_ma_monitor dut_i (
        .clk(clk), .rst(rst), .ma_valid(ma_valid), .ma_byte(ma_byte),
        .ferf_len5(ferf_len5), .tmark_len5(tmark_len5),
        .late_rev_mode(late_rev_mode), .pt_expected(pt_expected),
        .ferf_state(ferf_state), .tmark_state(tmark_state),
        .pt_received(pt_received), .pt_mismatch(pt_mismatch),
        .pt_mismatch_irq(pt_mismatch_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    function automatic int run_len(input bit l5);
        return l5 ? 5 : 3;
    endfunction

    task automatic upd(inout logic st, inout int cnt, input logic b, input bit l5);
        if (b != st) begin
            if (cnt + 1 >= run_len(l5)) begin
                st  = b;
                cnt = 0;
            end else begin
                cnt++;
            end
        end else begin
            cnt = 0;
        end
    endtask

    function automatic logic mis_of(input logic [2:0] p, input logic [2:0] e, input logic leg);
        return !leg && (p != e);
    endfunction

    // one strobed frame, junk on the bus afterwards (R9)
    task automatic frame(input logic [7:0] b, input bit fl5, input bit tl5);
        logic nm;
        @(negedge clk);
        ma_byte = b; ma_valid = 1'b1; ferf_len5 = fl5; tmark_len5 = tl5;
        @(posedge clk);
        #1 ma_valid = 1'b0; ma_byte = 8'($urandom);
        upd(m_ferf, m_fcnt, b[7], fl5);
        if (!late_rev_mode) upd(m_tm, m_tcnt, b[0], tl5);
        m_pt = b[5:3];
        @(negedge clk);
        chk(ferf_state == m_ferf, "R3/R4/R5/R10 ferf", ferf_state, m_ferf);
        chk(tmark_state == m_tm, "R6/R8 tmark", tmark_state, m_tm);
        chk(pt_received == m_pt, "R2 pt_received", pt_received, m_pt);
        @(negedge clk);
        nm = mis_of(m_pt, pt_expected, late_rev_mode);
        chk(pt_mismatch == nm, "R7 mismatch", pt_mismatch, nm);
        chk(pt_mismatch_irq == (nm && !m_mis), "R7 irq", pt_mismatch_irq, nm && !m_mis);
        m_mis = nm;
        // idle bytes changed nothing (R9)
        chk(ferf_state == m_ferf, "R9 ferf idle", ferf_state, m_ferf);
    endtask

    task automatic set_cfg(input logic [2:0] e, input logic leg);
        logic nm;
        @(negedge clk);
        pt_expected = e; late_rev_mode = leg;
        @(negedge clk);
        nm = mis_of(m_pt, e, leg);
        chk(pt_mismatch == nm, "R7/R8 mismatch cfg", pt_mismatch, nm);
        chk(pt_mismatch_irq == (nm && !m_mis), "R7/R8 irq cfg", pt_mismatch_irq, nm && !m_mis);
        m_mis = nm;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; ma_valid = 1'b0; ma_byte = 8'hFF;
        ferf_len5 = 1'b0; tmark_len5 = 1'b0; late_rev_mode = 1'b0; pt_expected = 3'd0;
        m_ferf = 1'b0; m_tm = 1'b0; m_mis = 1'b0; m_fcnt = 0; m_tcnt = 0; m_pt = 3'd0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ferf_state == 1'b0, "R1 ferf", ferf_state, 0);
        chk(tmark_state == 1'b0, "R1 tmark", tmark_state, 0);
        chk(pt_received == 3'd0, "R1 pt", pt_received, 0);
        chk(pt_mismatch == 1'b0, "R1 mismatch", pt_mismatch, 0);
        chk(pt_mismatch_irq == 1'b0, "R1 irq", pt_mismatch_irq, 0);

        // R3: 3-frame set and clear
        repeat (3) frame(8'h80, 1'b0, 1'b0);
        chk(ferf_state == 1'b1, "R3 declared", ferf_state, 1);
        repeat (3) frame(8'h00, 1'b0, 1'b0);
        chk(ferf_state == 1'b0, "R3 cleared", ferf_state, 0);

        // R4: 5-frame set, R5: broken run
        repeat (4) frame(8'h80, 1'b1, 1'b0);
        frame(8'h00, 1'b1, 1'b0);
        chk(ferf_state == 1'b0, "R5 broken run", ferf_state, 0);
        repeat (5) frame(8'h80, 1'b1, 1'b0);
        chk(ferf_state == 1'b1, "R4 declared", ferf_state, 1);

        // R10: run of 3 under length 5, then switch to 3
        repeat (3) frame(8'h00, 1'b1, 1'b0);
        frame(8'h00, 1'b0, 1'b0);
        chk(ferf_state == 1'b0, "R10 switch", ferf_state, 0);

        // R6: timing marker with 5 frames
        repeat (4) frame(8'h01, 1'b0, 1'b1);
        chk(tmark_state == 1'b0, "R6 not yet", tmark_state, 0);
        frame(8'h01, 1'b0, 1'b1);
        chk(tmark_state == 1'b1, "R6 validated", tmark_state, 1);

        // R7: payload mismatch via frames and via expected value
        frame(8'h28, 1'b0, 1'b0);
        set_cfg(3'd5, 1'b0);
        set_cfg(3'd2, 1'b0);
        // R8: legacy mode suppresses mismatch and freezes marker
        set_cfg(3'd2, 1'b1);
        repeat (4) frame(8'h00, 1'b0, 1'b0);
        chk(tmark_state == 1'b1, "R8 tmark frozen", tmark_state, 1);
        set_cfg(3'd2, 1'b0);

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [7:0] b;
            int r;
            r = $urandom_range(0, 19);
            if (r == 0) set_cfg(3'($urandom), 1'($urandom_range(0, 3) == 0));
            b = 8'($urandom);
            if ($urandom_range(0, 3) != 0) b[7] = m_ferf ^ ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 3) != 0) b[0] = m_tm ^ ($urandom_range(0, 2) == 0);
            if ($urandom_range(0, 2) != 0) b[5:3] = pt_expected;
            frame(b, 1'($urandom), 1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule